// File: doc/BRIEF.md
# Black-Level Tracking Correction Loop

This block removes the dark offset from a raw 10-bit pixel stream. At the start of each frame it averages a fixed population of optical-black pixels. It then feeds that average into a first-order recursive filter whose two coefficients are chosen from small code tables. The filtered value is a correction, held in eighths of a code, and its integer part is subtracted from every pixel of the stream. A signed user offset is applied after the subtraction, and the result is clamped to the 10-bit range.

The filter does not update on every frame. Each measurement updates the correction only when one of four update conditions holds: always, a pending gain change, a pending shutter change, or a frame-count window that opens at reset. When no condition holds, the correction keeps its last value. With automatic compensation turned off, the correction is ignored and the offset register is subtracted from the pixels as a plain unsigned number.

Top module: `dark_level_loop`

## Requirements
- R1: After `frame_start`, the measurement is the sum of the first 1024 valid pixels flagged black, shifted right by 10. Further black pixels in the same frame do not change it.
- R2: With gain-A code `cfg_gain_a` equal to 00/01/10/11 (weight 0, 1/2, 1/4, 1/8), a new correction in eighths is computed as Dn = {0,4,2,1}·(M + P) + floor({0,4,6,8}·Dold / 8). M is the new measurement and P is the previous frame's measurement (0 after reset).
- R3: Gain-B code `cfg_gain_b` equal to 00/01/10/11 gives feedback weight 0, 1/2, 3/4, 1 (multipliers 0, 4, 6, 8 in the R2 formula).
- R4: When `cfg_ob_same` is 1, P is replaced by M in the R2 formula.
- R5: `cfg_upd_always` makes every measurement update the correction. Between measurements, and at any measurement where no update condition holds, the correction is unchanged.
- R6: A `gain_evt` pulse stays pending until an update happens. A measurement taken while a change is pending updates the correction when `cfg_upd_gain` is 1. A pulse in the same cycle as the measurement counts for that measurement.
- R7: `shut_evt` with `cfg_upd_shut` behaves like R6. Any update clears both pending flags.
- R8: With `cfg_upd_count` set, the first L+1 measurements after reset update the correction, where L is `cfg_count_len` (00 to 11) sampled during reset.
- R9: With `cfg_auto_en` = 1, the output is pixel − floor(D/8) ± `cfg_offset[6:0]`. Offset bit 7 = 1 adds the magnitude and bit 7 = 0 subtracts it.
- R10: With `cfg_auto_en` = 0, the output is pixel − `cfg_offset[7:0]`, taken as unsigned, and the correction has no effect.
- R11: The output is clamped to the range 0 to 1023.
- R12: `out_valid` and `out_data` follow the pixel input by exactly one clock, and both are 0 after reset.
- R13: The correction saturates at 16383 eighths instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame start pulse; restarts the black measurement |
| pix_valid | input | 1 | Pixel strobe |
| pix_black | input | 1 | Current pixel belongs to the black region |
| pix_data | input | 10 | Raw pixel code |
| gain_evt | input | 1 | Gain setting changed |
| shut_evt | input | 1 | Shutter setting changed |
| cfg_gain_a | input | 2 | Measurement weight code |
| cfg_gain_b | input | 2 | Feedback weight code |
| cfg_ob_same | input | 1 | Use current measurement for both terms |
| cfg_upd_always | input | 1 | Update at every measurement |
| cfg_upd_gain | input | 1 | Update after a gain change |
| cfg_upd_shut | input | 1 | Update after a shutter change |
| cfg_upd_count | input | 1 | Update in the window after reset |
| cfg_count_len | input | 2 | Window length minus one, in frames |
| cfg_auto_en | input | 1 | Apply the tracked correction |
| cfg_offset | input | 8 | User offset |
| out_valid | output | 1 | Corrected pixel strobe |
| out_data | output | 10 | Corrected pixel code |

## Verification
Two actions can fall in the same cycle: a gain or shutter change event, and completion of the black measurement, which is also when the filter decides whether to update. The bench drives a shutter pulse in exactly the cycle after the last black pixel is accepted, which is the cycle in which the measurement completes. It enables only the shutter condition and judges the outcome from the corrected active pixels of that same frame. Those pixels must show the new correction, and the following frame must show no further update.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  localparam int PIX_W_D  = 10;
  localparam int OB_LOG_D = 10;
  localparam int FRAC_D   = 3;
  localparam int CORR_W_D = 14;

  // measurement weight in eighths
  function automatic logic [3:0] weight_a(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd0;
      2'b01:   return 4'd4;
      2'b10:   return 4'd2;
      default: return 4'd1;
    endcase
  endfunction

  // feedback weight in eighths
  function automatic logic [3:0] weight_b(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd0;
      2'b01:   return 4'd4;
      2'b10:   return 4'd6;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/dlc_ob_accum.sv
module dlc_ob_accum #(
  parameter int PIX_W  = 10,
  parameter int OB_LOG = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             pix_valid,
  input  logic             pix_black,
  input  logic [PIX_W-1:0] pix_data,
  output logic             ob_done,
  output logic [PIX_W-1:0] ob_mean
);
  localparam int SUM_W = PIX_W + OB_LOG;
  localparam int CNT_W = OB_LOG + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'((1 << OB_LOG) - 1);

  logic [SUM_W-1:0] sum_q, sum_next;
  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign take     = pix_valid && pix_black && !cnt_q[OB_LOG];
  assign sum_next = sum_q + SUM_W'(pix_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      cnt_q   <= '0;
      ob_done <= 1'b0;
      ob_mean <= '0;
    end else begin
      ob_done <= 1'b0;
      if (frame_start) begin
        sum_q <= '0;
        cnt_q <= '0;
      end else if (take) begin
        sum_q <= sum_next;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          ob_done <= 1'b1;
          ob_mean <= PIX_W'(sum_next >> OB_LOG);
        end
      end
    end
  end
endmodule

// File: rtl/dlc_loop_filter.sv
module dlc_loop_filter
  import dlc_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int FRAC   = 3,
  parameter int CORR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ob_done,
  input  logic [PIX_W-1:0]  ob_mean,
  input  logic              gain_evt,
  input  logic              shut_evt,
  input  logic [1:0]        cfg_gain_a,
  input  logic [1:0]        cfg_gain_b,
  input  logic              cfg_ob_same,
  input  logic              cfg_upd_always,
  input  logic              cfg_upd_gain,
  input  logic              cfg_upd_shut,
  input  logic              cfg_upd_count,
  input  logic [1:0]        cfg_count_len,
  output logic [CORR_W-1:0] corr
);
  localparam int ACC_W = CORR_W + 4;
  localparam logic [ACC_W-1:0] CMAX = ACC_W'((1 << CORR_W) - 1);

  logic [PIX_W-1:0] prev_q;
  logic [2:0]       remain_q;
  logic             gain_pend_q, shut_pend_q;
  logic             gain_eff, shut_eff, do_upd;
  logic [PIX_W:0]   ob_pair;
  logic [ACC_W-1:0] a_term, b_prod, nxt;

  assign gain_eff = gain_pend_q || gain_evt;
  assign shut_eff = shut_pend_q || shut_evt;
  assign do_upd   = ob_done && (cfg_upd_always
                                || (cfg_upd_gain && gain_eff)
                                || (cfg_upd_shut && shut_eff)
                                || (cfg_upd_count && (remain_q != 3'd0)));

  always_comb begin
    ob_pair = (PIX_W+1)'(ob_mean) + (PIX_W+1)'(cfg_ob_same ? ob_mean : prev_q);
    a_term  = ACC_W'(ob_pair) * ACC_W'(weight_a(cfg_gain_a));
    b_prod  = ACC_W'(corr) * ACC_W'(weight_b(cfg_gain_b));
    nxt     = a_term + (b_prod >> FRAC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      corr        <= '0;
      prev_q      <= '0;
      remain_q    <= {1'b0, cfg_count_len} + 3'd1;
      gain_pend_q <= 1'b0;
      shut_pend_q <= 1'b0;
    end else begin
      if (ob_done) begin
        prev_q <= ob_mean;
        if (remain_q != 3'd0) remain_q <= remain_q - 3'd1;
      end
      if (do_upd) begin
        corr        <= (nxt > CMAX) ? CMAX[CORR_W-1:0] : nxt[CORR_W-1:0];
        gain_pend_q <= 1'b0;
        shut_pend_q <= 1'b0;
      end else begin
        if (gain_evt) gain_pend_q <= 1'b1;
        if (shut_evt) shut_pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dlc_pixel_fix.sv
module dlc_pixel_fix #(
  parameter int PIX_W  = 10,
  parameter int FRAC   = 3,
  parameter int CORR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic [CORR_W-1:0] corr,
  input  logic              cfg_auto_en,
  input  logic [7:0]        cfg_offset,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_data
);
  localparam int SW = CORR_W + 2;
  localparam logic signed [SW-1:0] PMAX = SW'((1 << PIX_W) - 1);

  logic signed [SW-1:0] dint, offs, val;

  always_comb begin
    dint = SW'(corr >> FRAC);
    if (!cfg_auto_en)
      offs = -SW'(cfg_offset);
    else if (cfg_offset[7])
      offs = SW'(cfg_offset[6:0]);
    else
      offs = -SW'(cfg_offset[6:0]);
    val = SW'(pix_data) + offs - (cfg_auto_en ? dint : SW'(0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= pix_valid;
      if (val < 0)          out_data <= '0;
      else if (val > PMAX)  out_data <= PMAX[PIX_W-1:0];
      else                  out_data <= val[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/dark_level_loop.sv
module dark_level_loop #(
  parameter int PIX_W  = dlc_pkg::PIX_W_D,
  parameter int OB_LOG = dlc_pkg::OB_LOG_D,
  parameter int FRAC   = dlc_pkg::FRAC_D,
  parameter int CORR_W = dlc_pkg::CORR_W_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             pix_valid,
  input  logic             pix_black,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             gain_evt,
  input  logic             shut_evt,
  input  logic [1:0]       cfg_gain_a,
  input  logic [1:0]       cfg_gain_b,
  input  logic             cfg_ob_same,
  input  logic             cfg_upd_always,
  input  logic             cfg_upd_gain,
  input  logic             cfg_upd_shut,
  input  logic             cfg_upd_count,
  input  logic [1:0]       cfg_count_len,
  input  logic             cfg_auto_en,
  input  logic [7:0]       cfg_offset,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data
);
  logic              ob_done;
  logic [PIX_W-1:0]  ob_mean;
  logic [CORR_W-1:0] corr;

  dlc_ob_accum #(.PIX_W(PIX_W), .OB_LOG(OB_LOG)) u_accum (
    .clk(clk), .rst(rst), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_black(pix_black), .pix_data(pix_data), .ob_done(ob_done), .ob_mean(ob_mean)
  );

  dlc_loop_filter #(.PIX_W(PIX_W), .FRAC(FRAC), .CORR_W(CORR_W)) u_filter (
    .clk(clk), .rst(rst), .ob_done(ob_done), .ob_mean(ob_mean),
    .gain_evt(gain_evt), .shut_evt(shut_evt), .cfg_gain_a(cfg_gain_a),
    .cfg_gain_b(cfg_gain_b), .cfg_ob_same(cfg_ob_same),
    .cfg_upd_always(cfg_upd_always), .cfg_upd_gain(cfg_upd_gain),
    .cfg_upd_shut(cfg_upd_shut), .cfg_upd_count(cfg_upd_count),
    .cfg_count_len(cfg_count_len), .corr(corr)
  );

  dlc_pixel_fix #(.PIX_W(PIX_W), .FRAC(FRAC), .CORR_W(CORR_W)) u_fix (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
    .corr(corr), .cfg_auto_en(cfg_auto_en), .cfg_offset(cfg_offset),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
  parameter int PIX_W  = 10,
  parameter int CORR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_start,
  input logic              pix_valid,
  input logic [PIX_W-1:0]  pix_data,
  input logic              cfg_auto_en,
  input logic              out_valid,
  input logic [PIX_W-1:0]  out_data,
  input logic              ob_done,
  input logic [CORR_W-1:0] corr
);
  // R12: output strobe trails the input strobe by one clock
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> out_valid);
  a_r12_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !out_valid);
  // R5: correction moves only right after a measurement completes
  a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
    !ob_done |=> $stable(corr));
  // R1: one measurement per frame, none right after a frame start
  a_r1_single_done: assert property (@(posedge clk) disable iff (rst)
    ob_done |=> !ob_done);
  a_r1_start_clears: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !ob_done);
  // R10: manual mode only ever lowers a pixel
  a_r10_never_raises: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !cfg_auto_en) |=> (out_data <= $past(pix_data)));
endmodule

bind dark_level_loop dlc_checker #(.PIX_W(PIX_W), .CORR_W(CORR_W)) i_dlc_checker (
  .clk(clk), .rst(rst), .frame_start(frame_start), .pix_valid(pix_valid),
  .pix_data(pix_data), .cfg_auto_en(cfg_auto_en), .out_valid(out_valid),
  .out_data(out_data), .ob_done(ob_done), .corr(corr)
);

// File: tb/test_dark_level_loop.sv
`timescale 1ns/1ps
module test_dark_level_loop;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_start = 1'b0, pix_valid = 1'b0, pix_black = 1'b0;
  logic [9:0] pix_data = '0;
  logic       gain_evt = 1'b0, shut_evt = 1'b0;
  logic [1:0] cfg_gain_a = 2'b10, cfg_gain_b = 2'b01, cfg_count_len = 2'b00;
  logic       cfg_ob_same = 0, cfg_upd_always = 0, cfg_upd_gain = 0;
  logic       cfg_upd_shut = 0, cfg_upd_count = 0, cfg_auto_en = 1;
  logic [7:0] cfg_offset = 8'h80;
  logic       out_valid;
  logic [9:0] out_data;

  int errors = 0, checks = 0, cycles = 0;
  int exp_q[$];
  string tag_q[$];
  int m_d, m_prev, m_rem;
  bit m_gp, m_sp;
  int act_pix[7] = '{0, 5, 77, 300, 512, 700, 1023};

  dark_level_loop i_dark_level_loop (
    .clk(clk), .rst(rst), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_black(pix_black), .pix_data(pix_data), .gain_evt(gain_evt),
    .shut_evt(shut_evt), .cfg_gain_a(cfg_gain_a), .cfg_gain_b(cfg_gain_b),
    .cfg_ob_same(cfg_ob_same), .cfg_upd_always(cfg_upd_always),
    .cfg_upd_gain(cfg_upd_gain), .cfg_upd_shut(cfg_upd_shut),
    .cfg_upd_count(cfg_upd_count), .cfg_count_len(cfg_count_len),
    .cfg_auto_en(cfg_auto_en), .cfg_offset(cfg_offset),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  function automatic int ka(int c);
    case (c) 0: return 0; 1: return 4; 2: return 2; default: return 1; endcase
  endfunction
  function automatic int kb(int c);
    case (c) 0: return 0; 1: return 4; 2: return 6; default: return 8; endcase
  endfunction

  function automatic int model_pix(int p);
    int v;
    if (cfg_auto_en)
      v = p - (m_d / 8) + (cfg_offset[7] ? int'(cfg_offset[6:0]) : -int'(cfg_offset[6:0]));
    else
      v = p - int'(cfg_offset);
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  task automatic model_done(int mean, bit ge, bit se);
    bit g, s, upd;
    int p;
    g = m_gp | ge;
    s = m_sp | se;
    upd = cfg_upd_always || (cfg_upd_gain && g) || (cfg_upd_shut && s)
          || (cfg_upd_count && m_rem != 0);
    if (upd) begin
      p = cfg_ob_same ? mean : m_prev;
      m_d = ka(cfg_gain_a) * (mean + p) + (kb(cfg_gain_b) * m_d) / 8;
      if (m_d > 16383) m_d = 16383;
      m_gp = 0; m_sp = 0;
    end else begin
      m_gp = g; m_sp = s;
    end
    m_prev = mean;
    if (m_rem > 0) m_rem--;
  endtask

  task automatic push(int p, string tag);
    exp_q.push_back(model_pix(p));
    tag_q.push_back(tag);
  endtask

  task automatic do_reset(logic [1:0] len);
    cfg_count_len = len;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_d = 0; m_prev = 0; m_rem = int'(len) + 1; m_gp = 0; m_sp = 0;
  endtask

  task automatic pulse_gain();
    @(negedge clk) gain_evt = 1'b1;
    @(negedge clk) gain_evt = 1'b0;
    m_gp = 1;
  endtask

  task automatic run_frame(int v, int extra, bit se_at_done, string tag);
    int sum;
    sum = 0;
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    for (int i = 0; i < 1024; i++) begin
      pix_valid = 1'b1; pix_black = 1'b1; pix_data = 10'(v + (i & 1));
      sum += v + (i & 1);
      push(v + (i & 1), tag);
      @(negedge clk);
    end
    pix_valid = 1'b0; pix_black = 1'b0;
    shut_evt = se_at_done;
    model_done(sum >> 10, 1'b0, se_at_done);
    @(negedge clk) shut_evt = 1'b0;
    @(negedge clk);
    for (int i = 0; i < extra; i++) begin   // R1: black pixels past the 1024th
      pix_valid = 1'b1; pix_black = 1'b1; pix_data = 10'd1023;
      push(1023, tag);
      @(negedge clk);
    end
    for (int i = 0; i < 7; i++) begin
      pix_valid = 1'b1; pix_black = 1'b0; pix_data = 10'(act_pix[i]);
      push(act_pix[i], tag);
      @(negedge clk);
    end
    pix_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12: out_valid=1 expected 0 (no pending pixel)");
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (int'(out_data) != e) begin
          errors++;
          $display("FAIL %s: out_data=%0d expected %0d", t, out_data, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    cfg_upd_count = 1;
    do_reset(2'b01);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 10'd0) begin
      errors++;
      $display("FAIL R12: reset out_valid=%0b out_data=%0d expected 0 0", out_valid, out_data);
    end
    // R8 / R2 / R3: two-frame window, a=1/4, b=1/2
    run_frame(100, 0, 0, "R8");
    run_frame(100, 0, 0, "R3");
    run_frame(300, 0, 0, "R8");      // window closed: hold
    // R5: no condition holds
    cfg_upd_count = 0; cfg_upd_gain = 1;
    run_frame(400, 0, 0, "R5");
    // R6: pending gain change, extra black pixels ignored (R1)
    pulse_gain();
    run_frame(400, 4, 0, "R6");
    run_frame(250, 0, 0, "R1");
    // R7: shutter change in the measurement-complete cycle
    cfg_upd_gain = 0; cfg_upd_shut = 1;
    run_frame(200, 0, 1, "R7");
    run_frame(220, 0, 0, "R7");
    // R4: same-frame term, a=1/8, b=0
    cfg_upd_shut = 0; cfg_upd_always = 1; cfg_gain_a = 2'b11; cfg_gain_b = 2'b00; cfg_ob_same = 1;
    run_frame(600, 0, 0, "R4");
    // R13 / R11: a=1/2, b=1 drives saturation, outputs clamp low
    cfg_ob_same = 0; cfg_gain_a = 2'b01; cfg_gain_b = 2'b11;
    run_frame(1000, 0, 0, "R2");
    run_frame(1000, 0, 0, "R13");
    run_frame(1000, 0, 0, "R11");
    // R10: manual unsigned subtract
    cfg_auto_en = 0; cfg_offset = 8'd200; cfg_gain_a = 2'b00; cfg_gain_b = 2'b00;
    run_frame(50, 0, 0, "R10");
    // R9 / R11: zero correction, +127, clamps high
    cfg_auto_en = 1; cfg_offset = 8'hFF;
    run_frame(50, 0, 0, "R11");
    // R9: subtract magnitude, a=1/4, b=3/4
    cfg_offset = 8'h05; cfg_gain_a = 2'b10; cfg_gain_b = 2'b10;
    run_frame(50, 0, 0, "R9");
    run_frame(80, 0, 0, "R9");
    // R8: one-frame window after a new reset
    cfg_upd_always = 0; cfg_upd_count = 1;
    do_reset(2'b00);
    run_frame(120, 0, 0, "R8");
    run_frame(500, 0, 0, "R8");
    repeat (5) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12: outstanding=%0d expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule